// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Non-Maskable Bypass

This block sits between a group of peripheral interrupt sources and a processor core. Each peripheral raises a one-cycle event strobe. The strobe sets a pending flag for that source. The flag reaches the core only while the source's enable bit is 1 and the core's global interrupt mask input is 0. A non-maskable interrupt line and an address-break strobe are also collected. Both of these bypass the global mask.

All pending, unmasked requests compete under a fixed priority: the non-maskable line first, then the address break, then the peripherals with index 0 highest. Only the winner is shown to the core, as a registered request and vector number. The core takes the request by pulsing an accept strobe, which clears the pending bit of the source shown at that moment. Every other pending request stays pending and wins a later round. Software can drop a peripheral flag with a per-source clear strobe.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `irqReq` is 0, `irqVec` is 0 and every bit of `flagOut` is 0.
- R2: A peripheral flag (`flagOut[i]`) is set by a `srcEvent[i]` pulse whatever the enable. The flag is offered to the core only while `srcEnable[i]` is 1. Clearing `srcEnable[i]` withdraws the request but keeps the flag.
- R3: Priority is fixed, from highest to lowest: non-maskable line, address break, peripheral 0, peripheral 1, and so on to the last peripheral.
- R4: Non-maskable and address-break requests are presented while `iMask` is 1.
- R5: While `iMask` is 1, no peripheral request is presented, and peripheral flags stay set. After `iMask` returns to 0, the highest enabled pending peripheral is presented.
- R6: Vector encoding (defaults): non-maskable = 2, address break = 3, peripheral i = 16 + i. While `irqReq` is 0, `irqVec` is 0.
- R7: The non-maskable line is edge-triggered. A 0-to-1 transition of `nmiIn` latches one request. Holding the line high does not raise a second request after that one is accepted.
- R8: A cycle with `irqAccept` = 1 and `irqReq` = 1 clears the pending bit of the source presented in that cycle. The next-highest pending request is presented in the following cycle. `irqAccept` while `irqReq` is 0 changes nothing.
- R9: A `flagClr[i]` pulse clears flag i. If `srcEvent[i]` is 1 in the same cycle, the event wins and the flag stays set.
- R10: The presented vector is stable until accepted. It changes earlier only when a higher-priority request becomes pending, or when the presented request is withdrawn.
- R11: Latency is one clock edge. Inputs sampled at an edge (events, enables, mask, accept) appear on `irqReq`, `irqVec` and `flagOut` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | Per-peripheral event pulses |
| srcEnable | input | NUM_SRC | Per-peripheral enable bits |
| flagClr | input | NUM_SRC | Per-peripheral software clear strobes |
| nmiIn | input | 1 | Non-maskable interrupt line, rising-edge sensitive |
| brkIn | input | 1 | Address-break strobe, latched while high |
| iMask | input | 1 | Global mask for peripheral requests |
| irqAccept | input | 1 | Core accepts the presented request |
| irqReq | output | 1 | Request to the core |
| irqVec | output | VEC_W | Vector number of the presented request |
| flagOut | output | NUM_SRC | Pending flags of the peripherals |

## Verification
A wrong pending bit shows on `flagOut` and, once it wins arbitration, on `irqReq`/`irqVec` one edge after the stimulus that caused it. The bench's reference model therefore compares all three outputs every cycle. A lost or stuck latch for the non-maskable line or the address break shows as a vector that is missing or repeated after an accept. A wrong priority or mask decision shows as a wrong vector in the cycle right after the competing requests become pending. Acceptance is directed and randomised, so a clear aimed at the wrong source shows up as a flag that survives or vanishes in the next cycle.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_NMI  = 2'd1,
    KIND_BRK  = 2'd2,
    KIND_SRC  = 2'd3
  } srcKind_e;

  // clear strobes derived from the presented request and the accept
  typedef struct packed {
    logic             clrNmi;
    logic             clrBrk;
    logic             clrSrc;
    logic [IDX_W-1:0] clrIdx;
  } clrStrobes_t;

  // arbitration result loaded into the output registers
  typedef struct packed {
    srcKind_e         winKind;
    logic [IDX_W-1:0] winIdx;
  } selStrobes_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic                     irqAccept,
  input  srcKind_e                 curKind,
  input  logic [IDX_W-1:0]         curIdx,
  input  logic                     nmiPendNext,
  input  logic                     brkPendNext,
  input  logic [NUM_SRC-1:0]       srcPendNext,
  input  logic [NUM_SRC-1:0]       srcEnable,
  input  logic                     iMask,
  output clrStrobes_t              clr,
  output selStrobes_t              sel
);
  logic accepted;
  logic [NUM_SRC-1:0] srcLive;
  logic srcFound;
  logic [IDX_W-1:0] srcBest;

  assign accepted = irqAccept && (curKind != KIND_NONE);

  always_comb begin
    clr.clrNmi = accepted && (curKind == KIND_NMI);
    clr.clrBrk = accepted && (curKind == KIND_BRK);
    clr.clrSrc = accepted && (curKind == KIND_SRC);
    clr.clrIdx = curIdx;
  end

  // peripheral candidates: pending, enabled, global mask open
  assign srcLive = srcPendNext & srcEnable & {NUM_SRC{!iMask}};

  // lowest index wins among peripherals
  always_comb begin
    srcFound = 1'b0;
    srcBest  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcLive[i]) begin
        srcFound = 1'b1;
        srcBest  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel.winIdx = '0;
    if (nmiPendNext)      sel.winKind = KIND_NMI;
    else if (brkPendNext) sel.winKind = KIND_BRK;
    else if (srcFound) begin
      sel.winKind = KIND_SRC;
      sel.winIdx  = srcBest;
    end else              sel.winKind = KIND_NONE;
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int VEC_W        = 6,
  parameter int NMI_VEC      = 2,
  parameter int BRK_VEC      = 3,
  parameter int SRC_VEC_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic               nmiIn,
  input  logic               brkIn,
  input  clrStrobes_t        clr,
  input  selStrobes_t        sel,
  output logic               nmiPendNext,
  output logic               brkPendNext,
  output logic [NUM_SRC-1:0] srcPendNext,
  output srcKind_e           curKind,
  output logic [IDX_W-1:0]   curIdx,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic [NUM_SRC-1:0] flagOut
);
  logic nmiPrev, nmiPend, brkPend;
  logic [NUM_SRC-1:0] srcPend;
  logic [VEC_W-1:0] vecNext;

  // a new event has priority over any clear in the same cycle
  assign nmiPendNext = (nmiPend && !clr.clrNmi) || (nmiIn && !nmiPrev);
  assign brkPendNext = (brkPend && !clr.clrBrk) || brkIn;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    logic ackHit;
    assign ackHit = clr.clrSrc && (clr.clrIdx == IDX_W'(i));
    assign srcPendNext[i] = (srcPend[i] && !flagClr[i] && !ackHit) || srcEvent[i];
  end

  always_comb begin
    case (sel.winKind)
      KIND_NMI: vecNext = VEC_W'(NMI_VEC);
      KIND_BRK: vecNext = VEC_W'(BRK_VEC);
      KIND_SRC: vecNext = VEC_W'(SRC_VEC_BASE) + VEC_W'(sel.winIdx);
      default:  vecNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
      brkPend <= 1'b0;
      srcPend <= '0;
      curKind <= KIND_NONE;
      curIdx  <= '0;
      irqVec  <= '0;
    end else begin
      nmiPrev <= nmiIn;
      nmiPend <= nmiPendNext;
      brkPend <= brkPendNext;
      srcPend <= srcPendNext;
      curKind <= sel.winKind;
      curIdx  <= sel.winIdx;
      irqVec  <= vecNext;
    end
  end

  assign irqReq  = (curKind != KIND_NONE);
  assign flagOut = srcPend;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int VEC_W        = 6,
  parameter int NMI_VEC      = 2,
  parameter int BRK_VEC      = 3,
  parameter int SRC_VEC_BASE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic               nmiIn,
  input  logic               brkIn,
  input  logic               iMask,
  input  logic               irqAccept,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVec,
  output logic [NUM_SRC-1:0] flagOut
);
  clrStrobes_t clr;
  selStrobes_t sel;
  logic nmiPendNext, brkPendNext;
  logic [NUM_SRC-1:0] srcPendNext;
  srcKind_e curKind;
  logic [IDX_W-1:0] curIdx;

  irq_arb_ctrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .irqAccept  (irqAccept),
    .curKind    (curKind),
    .curIdx     (curIdx),
    .nmiPendNext(nmiPendNext),
    .brkPendNext(brkPendNext),
    .srcPendNext(srcPendNext),
    .srcEnable  (srcEnable),
    .iMask      (iMask),
    .clr        (clr),
    .sel        (sel)
  );

  irq_arb_dp #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC),
    .BRK_VEC(BRK_VEC), .SRC_VEC_BASE(SRC_VEC_BASE)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .srcEvent   (srcEvent),
    .flagClr    (flagClr),
    .nmiIn      (nmiIn),
    .brkIn      (brkIn),
    .clr        (clr),
    .sel        (sel),
    .nmiPendNext(nmiPendNext),
    .brkPendNext(brkPendNext),
    .srcPendNext(srcPendNext),
    .curKind    (curKind),
    .curIdx     (curIdx),
    .irqReq     (irqReq),
    .irqVec     (irqVec),
    .flagOut    (flagOut)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NUM_SRC      = 8,
  parameter int VEC_W        = 6,
  parameter int NMI_VEC      = 2,
  parameter int BRK_VEC      = 3,
  parameter int SRC_VEC_BASE = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEvent,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic [NUM_SRC-1:0] flagClr,
  input logic               iMask,
  input logic               irqAccept,
  input logic               irqReq,
  input logic [VEC_W-1:0]   irqVec,
  input logic [NUM_SRC-1:0] flagOut
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN)         cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  function automatic int rankOf(logic [VEC_W-1:0] v);
    if (v == VEC_W'(NMI_VEC)) return 0;
    if (v == VEC_W'(BRK_VEC)) return 1;
    return 2 + int'(v) - SRC_VEC_BASE;
  endfunction

  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVec == '0); // R6

  AST_MASK_HOLDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && irqReq && $past(iMask)) |->
      (irqVec == VEC_W'(NMI_VEC) || irqVec == VEC_W'(BRK_VEC))); // R5

  AST_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd2 && irqReq && $past(irqReq) && !$past(irqAccept) && !$past(|flagClr)
     && $past(srcEnable) == $past(srcEnable, 2) && $past(iMask) == $past(iMask, 2))
      |-> rankOf(irqVec) <= rankOf($past(irqVec))); // R10

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    AST_SRC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      (cyc != 2'd0 && irqReq && irqVec == VEC_W'(SRC_VEC_BASE + i)) |->
        (flagOut[i] && $past(srcEnable[i]))); // R2

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (irqAccept && irqReq && irqVec == VEC_W'(SRC_VEC_BASE + i) && !srcEvent[i])
        |=> !flagOut[i]); // R8

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      (flagOut[i] && !flagClr[i] &&
       !(irqAccept && irqReq && irqVec == VEC_W'(SRC_VEC_BASE + i)))
        |=> flagOut[i]); // R9

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      (cyc != 2'd0 && $rose(flagOut[i])) |-> $past(srcEvent[i])); // R2
  end
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC),
  .BRK_VEC(BRK_VEC), .SRC_VEC_BASE(SRC_VEC_BASE)
) chk_i (
  .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcEnable(srcEnable),
  .flagClr(flagClr), .iMask(iMask), .irqAccept(irqAccept),
  .irqReq(irqReq), .irqVec(irqVec), .flagOut(flagOut)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
  localparam int NS   = 8;
  localparam int VW   = 6;
  localparam int VNMI = 2;
  localparam int VBRK = 3;
  localparam int VBASE = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [NS-1:0] srcEvent, srcEnable, flagClr, flagOut;
  logic nmiIn, brkIn, iMask, irqAccept, irqReq;
  logic [VW-1:0] irqVec;

  int nChecks = 0;
  int nFail = 0;

  // reference model state
  logic mNmiPrev, mNmiP, mBrkP, mReq;
  logic [NS-1:0] mFlag;
  logic [VW-1:0] mVec;

  always #10 clk = ~clk;

  irq_arbiter #(.NUM_SRC(NS), .VEC_W(VW), .NMI_VEC(VNMI), .BRK_VEC(VBRK),
                .SRC_VEC_BASE(VBASE)) dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .srcEnable(srcEnable),
    .flagClr(flagClr), .nmiIn(nmiIn), .brkIn(brkIn), .iMask(iMask),
    .irqAccept(irqAccept), .irqReq(irqReq), .irqVec(irqVec), .flagOut(flagOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mNmiPrev = 0; mNmiP = 0; mBrkP = 0; mReq = 0; mFlag = '0; mVec = '0;
  endtask

  // next state from the requirements, using the inputs of this cycle
  task automatic modelStep();
    logic acc;
    logic found;
    acc = irqAccept && mReq;
    mNmiP = (mNmiP && !(acc && mVec == VW'(VNMI))) || (nmiIn && !mNmiPrev);
    mNmiPrev = nmiIn;
    mBrkP = (mBrkP && !(acc && mVec == VW'(VBRK))) || brkIn;
    for (int i = 0; i < NS; i++)
      mFlag[i] = (mFlag[i] && !flagClr[i] && !(acc && mVec == VW'(VBASE + i))) || srcEvent[i];
    found = 0;
    mReq = 1; mVec = '0;
    if (mNmiP) mVec = VW'(VNMI);
    else if (mBrkP) mVec = VW'(VBRK);
    else begin
      for (int i = 0; i < NS; i++)
        if (!found && !iMask && mFlag[i] && srcEnable[i]) begin
          found = 1; mVec = VW'(VBASE + i);
        end
      mReq = found;
    end
  endtask

  // one clock: model update, edge, compare at the falling edge, clear pulses
  task automatic step(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " req"}, 32'(irqReq), 32'(mReq));
    chk({tag, " vec"}, 32'(irqVec), 32'(mVec));
    chk({tag, " flags"}, 32'(flagOut), 32'(mFlag));
    srcEvent = '0; flagClr = '0; brkIn = 0; irqAccept = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd4711);
    rstN = 0; srcEvent = '0; srcEnable = '0; flagClr = '0;
    nmiIn = 0; brkIn = 0; iMask = 0; irqAccept = 0;
    modelReset();
    repeat (3) @(negedge clk);
    chk("R1 reset req", 32'(irqReq), 0);
    chk("R1 reset vec", 32'(irqVec), 0);
    chk("R1 reset flags", 32'(flagOut), 0);
    rstN = 1;
    step("R1 after reset");
    chk("R1 idle req", 32'(irqReq), 0);

    // R2 / R11: event while disabled sets flag only
    srcEvent[5] = 1; step("R2 disabled event");
    chk("R2 flag set", 32'(flagOut[5]), 1);
    chk("R2 no req", 32'(irqReq), 0);
    srcEnable[5] = 1; step("R11 enable");
    chk("R6 vec src5", 32'(irqVec), 21);

    // R3 / R10: higher sources take over
    srcEnable = '1; srcEvent[2] = 1; step("R3 src2");
    chk("R10 preempt src2", 32'(irqVec), 18);
    srcEvent[7] = 1; step("R10 lower arrival");
    chk("R10 stable on lower", 32'(irqVec), 18);
    brkIn = 1; step("R3 brk");
    chk("R6 vec brk", 32'(irqVec), 3);
    nmiIn = 1; step("R3 nmi");
    chk("R6 vec nmi", 32'(irqVec), 2);

    // R7 / R8: accept in priority order, nmi held high does not repeat
    irqAccept = 1; step("R8 acc nmi");
    chk("R7 no second nmi", 32'(irqVec), 3);
    irqAccept = 1; step("R8 acc brk");
    chk("R8 next src2", 32'(irqVec), 18);
    irqAccept = 1; step("R8 acc src2");
    chk("R8 next src5", 32'(irqVec), 21);
    irqAccept = 1; step("R8 acc src5");
    irqAccept = 1; step("R8 acc src7");
    chk("R8 drained", 32'(irqReq), 0);
    irqAccept = 1; step("R8 accept idle");
    chk("R8 idle accept no effect", 32'(flagOut), 0);
    nmiIn = 0; step("R7 nmi low");

    // R4 / R5: mask
    iMask = 1; srcEvent[1] = 1; step("R5 masked");
    chk("R5 masked no req", 32'(irqReq), 0);
    chk("R5 flag held", 32'(flagOut[1]), 1);
    brkIn = 1; step("R4 brk bypass");
    chk("R4 brk under mask", 32'(irqVec), 3);
    irqAccept = 1; step("R4 acc brk");
    nmiIn = 1; step("R4 nmi bypass");
    chk("R4 nmi under mask", 32'(irqVec), 2);
    irqAccept = 1; step("R4 acc nmi");
    iMask = 0; step("R5 unmask");
    chk("R5 released src1", 32'(irqVec), 17);

    // R9: software clear, event wins same cycle
    flagClr[1] = 1; step("R9 clear");
    chk("R9 cleared", 32'(flagOut[1]), 0);
    flagClr[3] = 1; srcEvent[3] = 1; step("R9 event wins");
    chk("R9 flag kept", 32'(flagOut[3]), 1);
    srcEnable[3] = 0; step("R2 disable keeps flag");
    chk("R2 withdrawn", 32'(irqReq), 0);
    chk("R2 flag remains", 32'(flagOut[3]), 1);
    srcEnable[3] = 1; step("R2 reenable");
    irqAccept = 1; step("R8 acc src3");
    nmiIn = 0;

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      srcEvent = NS'($urandom & $urandom & $urandom);
      flagClr  = NS'($urandom & $urandom & $urandom & $urandom);
      if ($urandom_range(0, 15) == 0) srcEnable = NS'($urandom);
      if ($urandom_range(0, 9) == 0) iMask = ~iMask;
      if ($urandom_range(0, 19) == 0) nmiIn = ~nmiIn;
      brkIn = ($urandom_range(0, 29) == 0);
      irqAccept = ($urandom_range(0, 9) < (mReq ? 4 : 1));
      step("R3 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule